// File: doc/BRIEF.md
# EDO DRAM Data-Output Drive Controller

This block decides, cycle by cycle, whether the four data pins of an extended-data-out DRAM model are driven and which value they carry. It watches the four active-low strobes (row strobe, column strobe, write strobe and output-enable strobe). It resynchronises them to a fast system clock and finds their edges. From these it keeps a held data-out register and a drive-enable flag. A read-data input stands in for the storage array. Its value is captured when the column strobe falls during a read access.

The defining property is that raising the column strobe does not release the pins. The last word read stays driven, so the host can latch it while the next column address is being set up. The output is released only by specific events: an output-enable high window that meets a minimum length, a write strobe asserted while the column strobe is high, a row strobe that rises while the column strobe is low, or an early write. Each such release is sticky and holds until the column strobe next falls. The minimum output-enable windows are parameters counted in clock cycles.

Top module: `edo_dq_ctrl`

## Requirements
- R1: A column-strobe fall (cas_ni 1->0) while ras_ni=0 and we_ni=1 copies rd_data_i into dq_data_o and, with oe_ni=0, sets dq_drive_o=1.
- R2: Raising the column strobe alone keeps dq_drive_o=1 and dq_data_o unchanged, and changes on rd_data_i while the column strobe is high do not reach dq_data_o.
- R3: If oe_ni=1 when the column strobe rises and stays 1 for at least OE_HOLD_CYC consecutive cycles from that rise, the output turns off and stays off until the next column-strobe fall whatever oe_ni does. A shorter window lets the drive return once oe_ni goes back to 0.
- R4: If oe_ni=0 when the column strobe rises, an oe_ni=1 pulse of at least OE_PULSE_CYC cycles during column-strobe-high time turns the output off until the next column-strobe fall. A shorter pulse does not.
- R5: we_ni=0 while the column strobe is high turns the output off until the next column-strobe fall, even after we_ni returns to 1.
- R6: we_ni=0 at a column-strobe fall (early write, including a write strobe that falls in the same cycle as the column strobe) keeps dq_drive_o=0 until the next column-strobe fall, even with oe_ni=0, and leaves dq_data_o unchanged.
- R7: While the column and row strobes are low and we_ni=1, oe_ni alone switches the drive: oe_ni=1 gives dq_drive_o=0 and oe_ni=0 gives dq_drive_o=1, with no lasting effect.
- R8: A row-strobe rise (ras_ni 0->1) while the column strobe is low turns the output off until the next column-strobe fall.
- R9: While rst_ni=0 and after it is released, dq_drive_o=0 and dq_data_o=0 until the first read access of R1.
- R10: A column-strobe fall while ras_ni=1 (refresh-style strobe order) loads nothing and keeps dq_drive_o=0 until the next column-strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output-enable strobe, active low |
| rd_data_i | input | DW | Read data from the array stand-in |
| dq_drive_o | output | 1 | 1 when the data pins are driven |
| dq_data_o | output | DW | Held data-out register |

## Verification
The write strobe and the column strobe can both fall in the same sampled cycle. In that case the column-strobe fall must resolve as an early write, not as a read that loads data and drives it. The bench provokes this by changing both pins at the same clock edge, with nothing set up beforehand. It judges the result by checking that the pins stay released and that the held word is still the one from the previous read. The window thresholds are exercised on both sides: random pulse and hold lengths are compared with the configured cycle counts.

// File: rtl/edo_pkg.sv
package edo_pkg;
  localparam int unsigned STROBES = 4;

  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic oe;
  } strobe_t;
endpackage

// File: rtl/edo_strobe_sync.sv
module edo_strobe_sync
  import edo_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  strobe_t raw_ni,
  output strobe_t act_o,
  output strobe_t act_prev_o
);
  logic [STROBES-1:0] pipe [STAGES];
  logic [STROBES-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe[s] <= '1;
      else if (s == 0) pipe[s] <= raw_ni;
      else pipe[s] <= pipe[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else prev_q <= pipe[STAGES-1];
  end

  assign act_o      = strobe_t'(~pipe[STAGES-1]);
  assign act_prev_o = strobe_t'(~prev_q);
endmodule

// File: rtl/edo_oe_window.sv
module edo_oe_window #(
  parameter int unsigned HOLD_CYC  = 3,
  parameter int unsigned PULSE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cas_high_i,
  input  logic cas_rise_i,
  input  logic cas_fall_i,
  input  logic oe_act_i,
  output logic oe_off_o
);
  localparam int unsigned MAXT = (HOLD_CYC > PULSE_CYC) ? HOLD_CYC : PULSE_CYC;
  localparam int unsigned CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt_q, cnt_n, thr;
  logic          hold_q, hold_mode, off_q;

  // mode is picked by OE level at the very cycle CAS rises
  assign hold_mode = cas_rise_i ? ~oe_act_i : hold_q;
  assign thr       = hold_mode ? CW'(HOLD_CYC) : CW'(PULSE_CYC);
  assign cnt_n     = (cnt_q == CW'(MAXT)) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
      off_q  <= 1'b0;
    end else begin
      if (cas_rise_i) hold_q <= ~oe_act_i;
      else if (oe_act_i) hold_q <= 1'b0;

      if (cas_fall_i) begin
        cnt_q <= '0;
        off_q <= 1'b0;
      end else if (cas_high_i && !oe_act_i) begin
        cnt_q <= cnt_n;
        if (cnt_n >= thr) off_q <= 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign oe_off_o = off_q;
endmodule

// File: rtl/edo_dq_ctrl.sv
module edo_dq_ctrl
  import edo_pkg::*;
#(
  parameter int unsigned DW          = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OE_HOLD_CYC  = 3,
  parameter int unsigned OE_PULSE_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [DW-1:0] rd_data_i,
  output logic          dq_drive_o,
  output logic [DW-1:0] dq_data_o
);
  strobe_t raw, act, prev;
  logic    ras_a, cas_a, we_a, oe_a;
  logic    cas_fall, cas_rise, ras_rise;
  logic    oe_off;
  logic    blank_q, we_off_q, ras_off_q, have_q;
  logic [DW-1:0] data_q;

  assign raw = '{ras: ras_ni, cas: cas_ni, we: we_ni, oe: oe_ni};

  edo_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .raw_ni     (raw),
    .act_o      (act),
    .act_prev_o (prev)
  );

  assign ras_a    = act.ras;
  assign cas_a    = act.cas;
  assign we_a     = act.we;
  assign oe_a     = act.oe;
  assign cas_fall = cas_a & ~prev.cas;
  assign cas_rise = ~cas_a & prev.cas;
  assign ras_rise = ~ras_a & prev.ras;

  edo_oe_window #(.HOLD_CYC(OE_HOLD_CYC), .PULSE_CYC(OE_PULSE_CYC)) u_oe_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cas_high_i (~cas_a),
    .cas_rise_i (cas_rise),
    .cas_fall_i (cas_fall),
    .oe_act_i   (oe_a),
    .oe_off_o   (oe_off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_q   <= 1'b0;
      we_off_q  <= 1'b0;
      ras_off_q <= 1'b0;
      have_q    <= 1'b0;
      data_q    <= '0;
    end else if (cas_fall) begin
      we_off_q  <= 1'b0;
      ras_off_q <= 1'b0;
      // early write or refresh-order strobes: no access, pins stay released
      if (we_a || !ras_a) begin
        blank_q <= 1'b1;
      end else begin
        blank_q <= 1'b0;
        have_q  <= 1'b1;
        data_q  <= rd_data_i;
      end
    end else begin
      if (!cas_a && we_a) we_off_q <= 1'b1;
      if (cas_a && ras_rise) ras_off_q <= 1'b1;
    end
  end

  assign dq_drive_o = have_q & oe_a & ~we_a & ~blank_q & ~we_off_q & ~ras_off_q & ~oe_off;
  assign dq_data_o  = data_q;
endmodule

// File: rtl/edo_dq_ctrl_chk.sv
module edo_dq_ctrl_chk #(
  parameter int unsigned DW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ras_a,
  input logic          cas_a,
  input logic          we_a,
  input logic          oe_a,
  input logic          cas_fall,
  input logic          ras_rise,
  input logic          oe_off,
  input logic          dq_drive_o,
  input logic [DW-1:0] dq_data_o
);
  // R1 R2: held word changes only right after a read-type CAS fall
  assert_data_on_read_fall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dq_data_o) |-> $past(cas_fall && !we_a && ras_a));

  // R3 R4: window-based turn-off persists until CAS falls
  assert_oe_window_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_off && !cas_fall) |=> !dq_drive_o);

  assert_we_high_cas_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_a && we_a && !cas_fall) |=> !dq_drive_o);

  assert_early_write_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_fall && we_a) |=> !dq_drive_o);

  assert_drive_needs_oe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_drive_o) |-> oe_a);

  assert_ras_rise_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_a && ras_rise) |=> !dq_drive_o);
endmodule

bind edo_dq_ctrl edo_dq_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ras_a      (ras_a),
  .cas_a      (cas_a),
  .we_a       (we_a),
  .oe_a       (oe_a),
  .cas_fall   (cas_fall),
  .ras_rise   (ras_rise),
  .oe_off     (oe_off),
  .dq_drive_o (dq_drive_o),
  .dq_data_o  (dq_data_o)
);

// File: tb/edo_dq_ctrl_test.sv
module edo_dq_ctrl_test;
  localparam int DW    = 4;
  localparam int HOLD  = 3;
  localparam int PULSE = 2;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [DW-1:0] rd = '0;
  logic drive;
  logic [DW-1:0] dq;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] last_d = '0;
  int unsigned seed_val;

  always #2.5 clk = ~clk;

  edo_dq_ctrl #(.DW(DW), .SYNC_STAGES(2), .OE_HOLD_CYC(HOLD), .OE_PULSE_CYC(PULSE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n),
    .oe_ni(oe_n), .rd_data_i(rd), .dq_drive_o(drive), .dq_data_o(dq)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic exp_drv, logic [DW-1:0] exp_d);
    n_chk++;
    if (drive !== exp_drv || dq !== exp_d) begin
      n_bad++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h", req, drive, dq, exp_drv, exp_d);
    end
  endtask

  function automatic logic exp_after_window(int len, int thr);
    return (len < thr);
  endfunction

  // full read access ending with CAS low, OE low
  task automatic do_read(logic [DW-1:0] d);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; ras_n = 1'b1;
    step(3);
    ras_n = 1'b0; rd = d;
    step(2);
    cas_n = 1'b0;
    step(SETTLE);
    last_d = d;
    check("R1", 1'b1, d);
  endtask

  task automatic pulse_test(int n, logic [DW-1:0] d);
    do_read(d);
    cas_n = 1'b1;
    step(SETTLE);
    check("R2", 1'b1, d);
    oe_n = 1'b1;
    step(n);
    oe_n = 1'b0;
    step(SETTLE);
    check("R4", exp_after_window(n, PULSE), d);
  endtask

  task automatic hold_test(int m, logic [DW-1:0] d);
    do_read(d);
    oe_n = 1'b1;
    step(SETTLE);
    check("R7", 1'b0, d);
    cas_n = 1'b1;
    step(m);
    oe_n = 1'b0;
    step(SETTLE);
    check("R3", exp_after_window(m, HOLD), d);
    if (m >= HOLD) begin
      oe_n = 1'b1; step(4); oe_n = 1'b0; step(SETTLE);
      check("R3", 1'b0, d);
    end
  endtask

  task automatic we_test(logic [DW-1:0] d);
    do_read(d);
    cas_n = 1'b1;
    step(SETTLE);
    we_n = 1'b0;
    step(SETTLE);
    check("R5", 1'b0, d);
    we_n = 1'b1;
    step(SETTLE);
    check("R5", 1'b0, d);
  endtask

  task automatic early_test(logic [DW-1:0] d, logic [DW-1:0] other, logic same_edge);
    do_read(d);
    cas_n = 1'b1;
    step(SETTLE);
    rd = other;
    if (!same_edge) begin
      we_n = 1'b0;
      step(3);
    end
    cas_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    step(SETTLE);
    check("R6", 1'b0, d);
    cas_n = 1'b1; we_n = 1'b1;
    step(SETTLE);
    check("R6", 1'b0, d);
  endtask

  task automatic ras_test(logic [DW-1:0] d);
    do_read(d);
    ras_n = 1'b1;
    step(SETTLE);
    check("R8", 1'b0, d);
    ras_n = 1'b0;
    step(SETTLE);
    check("R8", 1'b0, d);
    cas_n = 1'b1;
    step(SETTLE);
    check("R8", 1'b0, d);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: drive=%0b expected run to finish", drive);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    seed_val = 32'd20240611;
    void'($urandom(seed_val));
    step(3);
    check("R9", 1'b0, '0);
    rst_n = 1'b1;
    step(SETTLE);
    check("R9", 1'b0, '0);

    // R7 direct OE control during CAS low
    do_read(4'hA);
    oe_n = 1'b1; step(SETTLE); check("R7", 1'b0, 4'hA);
    oe_n = 1'b0; step(SETTLE); check("R7", 1'b1, 4'hA);

    // R2: held through CAS high, new array data ignored
    cas_n = 1'b1; step(SETTLE); check("R2", 1'b1, 4'hA);
    rd = 4'h5; step(SETTLE); check("R2", 1'b1, 4'hA);

    // window boundaries on both sides
    pulse_test(PULSE - 1, 4'h3);
    pulse_test(PULSE, 4'hC);
    hold_test(HOLD - 1, 4'h6);
    hold_test(HOLD, 4'h9);

    we_test(4'h1);
    do_read(4'h2);
    early_test(4'h7, 4'h8, 1'b0);
    early_test(4'hE, 4'h1, 1'b1);  // W and CAS fall in the same cycle
    ras_test(4'hB);

    // R10: CAS falls while RAS is high
    do_read(4'hD);
    cas_n = 1'b1; ras_n = 1'b1; step(SETTLE);
    rd = 4'h4; cas_n = 1'b0; step(SETTLE);
    check("R10", 1'b0, 4'hD);
    cas_n = 1'b1; step(SETTLE);

    for (int i = 0; i < 60; i++) begin
      logic [DW-1:0] d = DW'($urandom);
      int sel = int'($urandom % 5);
      case (sel)
        0: pulse_test(1 + int'($urandom % 4), d);
        1: hold_test(1 + int'($urandom % 5), d);
        2: we_test(d);
        3: early_test(d, ~d, logic'($urandom % 2));
        default: ras_test(d);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule